// File: doc/BRIEF.md
# Packed BCD Time-of-Day Counter

This block holds the time of day as three packed BCD bytes (hours, minutes, seconds) and moves it forward by one second on each strobe from a one-second timebase. The stored value feeds a display driver or a time-code encoder directly, with no binary-to-decimal conversion downstream.

Two single-cycle commands step the time one second ahead or one second back. Repeated steps place the clock at any offset from UTC, such as a time-zone offset or the one-minute lead that time-code transmission needs. One backward step inserts a leap second by hand. A parallel preset loads all three bytes at once. The block accepts a preset only when every byte is a legal value for its field. Otherwise it ignores the preset.

The strobe and the two step commands add up into one signed change per cycle. That change ripples as a carry or a borrow through seconds, minutes and hours.

Top module: `bcd_tod_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all three output bytes are 0x00, which reads as 00:00:00.
- R2: Each output byte is packed BCD. Bits [7:4] hold the tens digit and bits [3:0] hold the units digit, and both digits are always in the range 0 to 9.
- R3: Each strobe on `sec_tick_i` adds one second, visible on the cycle after the strobe. The seconds units digit rolls over after 9, and the seconds byte rolls over after 59 to 00 with a carry into minutes.
- R4: Minutes roll over after 59 to 00 with a carry into hours. Hours roll over after 23 to 00, so 23:59:59 plus one second gives 00:00:00.
- R5: A pulse on `step_fwd_i` with no strobe adds one second, with the same carries as R3 and R4.
- R6: A pulse on `step_back_i` with no strobe subtracts one second. Borrows ripple through the fields, so 10:00:00 becomes 09:59:59.
- R7: A backward step from 00:00:00 gives 23:59:59.
- R8: Strobe and steps in the same cycle combine into a net change of strobe + forward − back. Strobe with forward adds two seconds. Strobe with back, or forward with back, leaves the time unchanged. All three together add one second.
- R9: When `preset_i` is high and all three preset bytes are legal, the next cycle shows exactly the preset bytes. Any strobe or step in that cycle is ignored.
- R10: A preset is illegal if any digit is above 9, or if its byte value is 60 or more for seconds or minutes, or 24 or more for hours. An illegal preset has no effect: the time changes only as R3 to R8 dictate for that cycle.
- R11: In a cycle with no strobe, no step and no accepted preset, the time holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sec_tick_i | input | 1 | One-second strobe from the timebase, one cycle wide |
| step_fwd_i | input | 1 | Step command: one second ahead |
| step_back_i | input | 1 | Step command: one second back |
| preset_i | input | 1 | Load the preset bytes |
| preset_hh_i | input | 8 | Preset hours, packed BCD |
| preset_mm_i | input | 8 | Preset minutes, packed BCD |
| preset_ss_i | input | 8 | Preset seconds, packed BCD |
| hh_o | output | 8 | Hours, packed BCD |
| mm_o | output | 8 | Minutes, packed BCD |
| ss_o | output | 8 | Seconds, packed BCD |

## Verification
The bench builds the block with its default field moduli of 60, 60 and 24, which are the values a real clock uses. Presets place the time just before the boundaries: a units rollover, a tens rollover, the hour step and the midnight wrap. This reaches every carry and borrow path in a few cycles instead of counting through a whole day. A long random stretch then mixes strobes, steps, and legal and illegal presets, so every combination of the step inputs meets every kind of boundary.

// File: rtl/bcd_tod_pkg.sv
package bcd_tod_pkg;

   // One packed BCD field: tens digit in [7:4], units digit in [3:0]
   typedef logic [7:0] bcd_byte_t;

   // Signed per-cycle change; the seconds field sees -1..+2, the others -1..+1
   typedef logic signed [2:0] step_t;

   localparam int unsigned DIGIT_BASE = 10;
   localparam int unsigned MAX_FIELD_MOD = 100;

endpackage

// File: rtl/bcd_tod_delta.sv
module bcd_tod_delta
   import bcd_tod_pkg::*;
(
   input  logic  tick_i,
   input  logic  fwd_i,
   input  logic  back_i,
   output step_t delta_o
);

   always_comb begin
      unique case ({tick_i, fwd_i, back_i})
         3'b000:  delta_o = 3'sd0;
         3'b001:  delta_o = -3'sd1;
         3'b010:  delta_o = 3'sd1;
         3'b011:  delta_o = 3'sd0;
         3'b100:  delta_o = 3'sd1;
         3'b101:  delta_o = 3'sd0;
         3'b110:  delta_o = 3'sd2;
         default: delta_o = 3'sd1;
      endcase
   end

endmodule

// File: rtl/bcd_tod_field.sv
module bcd_tod_field
   import bcd_tod_pkg::*;
#(
   parameter int unsigned MODULUS = 60
)(
   input  bcd_byte_t cur_i,
   input  step_t     delta_i,
   output bcd_byte_t nxt_o
);

   localparam logic signed [8:0] MOD_S = 9'(MODULUS);
   localparam logic [7:0]        TEN   = 8'(DIGIT_BASE);

   logic [7:0]        bin;
   logic signed [8:0] sum;
   logic signed [8:0] wrapped;
   logic [7:0]        mag;

   always_comb begin
      bin = 8'(cur_i[7:4]) * TEN + 8'(cur_i[3:0]);
      sum = $signed({1'b0, bin}) + 9'(delta_i);
      if (sum >= MOD_S) begin
         wrapped = sum - MOD_S;
      end else if (sum < 9'sd0) begin
         wrapped = sum + MOD_S;
      end else begin
         wrapped = sum;
      end
      mag   = 8'(wrapped);
      nxt_o = {4'(mag / TEN), 4'(mag % TEN)};
   end

endmodule

// File: rtl/bcd_tod_carry.sv
module bcd_tod_carry
   import bcd_tod_pkg::*;
#(
   parameter int unsigned MODULUS = 60
)(
   input  bcd_byte_t cur_i,
   input  step_t     delta_i,
   output step_t     carry_o
);

   localparam logic [7:0] TOP_VAL = 8'(MODULUS - 1);
   localparam logic [7:0] TEN     = 8'(DIGIT_BASE);

   logic [7:0] bin;

   always_comb begin
      bin = 8'(cur_i[7:4]) * TEN + 8'(cur_i[3:0]);
      if ((delta_i == 3'sd1 && bin == TOP_VAL) ||
          (delta_i == 3'sd2 && bin >= TOP_VAL - 8'd1)) begin
         carry_o = 3'sd1;
      end else if (delta_i == -3'sd1 && bin == 8'd0) begin
         carry_o = -3'sd1;
      end else begin
         carry_o = 3'sd0;
      end
   end

endmodule

// File: rtl/bcd_tod_bcd_legal.sv
module bcd_tod_bcd_legal
   import bcd_tod_pkg::*;
#(
   parameter int unsigned MODULUS = 60
)(
   input  bcd_byte_t val_i,
   output logic      ok_o
);

   localparam logic [7:0] LIMIT = 8'(MODULUS);
   localparam logic [3:0] DMAX  = 4'(DIGIT_BASE - 1);

   logic [7:0] bin;

   always_comb begin
      bin  = 8'(val_i[7:4]) * 8'(DIGIT_BASE) + 8'(val_i[3:0]);
      ok_o = (val_i[7:4] <= DMAX) && (val_i[3:0] <= DMAX) && (bin < LIMIT);
   end

endmodule

// File: rtl/bcd_tod_counter.sv
module bcd_tod_counter
   import bcd_tod_pkg::*;
#(
   parameter int unsigned SEC_MOD  = 60,
   parameter int unsigned MIN_MOD  = 60,
   parameter int unsigned HOUR_MOD = 24
)(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       sec_tick_i,
   input  logic       step_fwd_i,
   input  logic       step_back_i,
   input  logic       preset_i,
   input  logic [7:0] preset_hh_i,
   input  logic [7:0] preset_mm_i,
   input  logic [7:0] preset_ss_i,
   output logic [7:0] hh_o,
   output logic [7:0] mm_o,
   output logic [7:0] ss_o
);

   localparam int NUM_FIELDS = 3;

   function automatic int unsigned field_mod(input int idx);
      case (idx)
         0:       return SEC_MOD;
         1:       return MIN_MOD;
         default: return HOUR_MOD;
      endcase
   endfunction

   // Elaboration-time parameter checks
   if (SEC_MOD < 3 || SEC_MOD > MAX_FIELD_MOD) begin : g_bad_sec
      $error("SEC_MOD must lie in 3..100");
   end
   if (MIN_MOD < 2 || MIN_MOD > MAX_FIELD_MOD) begin : g_bad_min
      $error("MIN_MOD must lie in 2..100");
   end
   if (HOUR_MOD < 2 || HOUR_MOD > MAX_FIELD_MOD) begin : g_bad_hour
      $error("HOUR_MOD must lie in 2..100");
   end

   bcd_byte_t             cur_q [NUM_FIELDS];
   bcd_byte_t             nxt   [NUM_FIELDS];
   bcd_byte_t             pre   [NUM_FIELDS];
   step_t                 chain [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] pre_ok;

   assign pre[0] = preset_ss_i;
   assign pre[1] = preset_mm_i;
   assign pre[2] = preset_hh_i;

   bcd_tod_delta u_delta (
      .tick_i  (sec_tick_i),
      .fwd_i   (step_fwd_i),
      .back_i  (step_back_i),
      .delta_o (chain[0])
   );

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      bcd_tod_field #(.MODULUS(field_mod(g))) u_field (
         .cur_i   (cur_q[g]),
         .delta_i (chain[g]),
         .nxt_o   (nxt[g])
      );

      bcd_tod_bcd_legal #(.MODULUS(field_mod(g))) u_legal (
         .val_i (pre[g]),
         .ok_o  (pre_ok[g])
      );

      if (g < NUM_FIELDS - 1) begin : g_carry
         bcd_tod_carry #(.MODULUS(field_mod(g))) u_carry (
            .cur_i   (cur_q[g]),
            .delta_i (chain[g]),
            .carry_o (chain[g+1])
         );
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int i = 0; i < NUM_FIELDS; i++) cur_q[i] <= '0;
      end else if (preset_i && (&pre_ok)) begin
         for (int i = 0; i < NUM_FIELDS; i++) cur_q[i] <= pre[i];
      end else begin
         for (int i = 0; i < NUM_FIELDS; i++) cur_q[i] <= nxt[i];
      end
   end

   assign ss_o = cur_q[0];
   assign mm_o = cur_q[1];
   assign hh_o = cur_q[2];

endmodule

// File: rtl/bcd_tod_checker.sv
module bcd_tod_checker #(
   parameter int unsigned SEC_MOD  = 60,
   parameter int unsigned MIN_MOD  = 60,
   parameter int unsigned HOUR_MOD = 24
)(
   input logic       clk_i,
   input logic       rst_ni,
   input logic       sec_tick_i,
   input logic       step_fwd_i,
   input logic       step_back_i,
   input logic       preset_i,
   input logic [7:0] preset_hh_i,
   input logic [7:0] preset_mm_i,
   input logic [7:0] preset_ss_i,
   input logic [7:0] hh_o,
   input logic [7:0] mm_o,
   input logic [7:0] ss_o
);

   function automatic int dec(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic bit legal(input logic [7:0] b, input int unsigned m);
      return (b[7:4] < 4'd10) && (b[3:0] < 4'd10) && (dec(b) < int'(m));
   endfunction

   logic quiet, all_pre_ok;
   assign quiet      = !sec_tick_i && !step_fwd_i && !step_back_i;
   assign all_pre_ok = legal(preset_ss_i, SEC_MOD) && legal(preset_mm_i, MIN_MOD) &&
                       legal(preset_hh_i, HOUR_MOD);

   AST_DIGITS_DECIMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ss_o[3:0] < 4'd10 && ss_o[7:4] < 4'd10 && mm_o[3:0] < 4'd10 && mm_o[7:4] < 4'd10 && hh_o[3:0] < 4'd10 && hh_o[7:4] < 4'd10); // R2

   AST_SEC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec(ss_o) < int'(SEC_MOD) && dec(mm_o) < int'(MIN_MOD)); // R3

   AST_HOUR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec(hh_o) < int'(HOUR_MOD)); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      quiet && !preset_i |=> $stable(ss_o) && $stable(mm_o) && $stable(hh_o)); // R11

   AST_PRESET_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      preset_i && all_pre_ok |=> ss_o == $past(preset_ss_i) && mm_o == $past(preset_mm_i) && hh_o == $past(preset_hh_i)); // R9

   AST_PRESET_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      preset_i && !all_pre_ok && quiet |=> $stable(ss_o) && $stable(mm_o) && $stable(hh_o)); // R10

   AST_BACK_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_back_i && !step_fwd_i && !sec_tick_i && !preset_i && ss_o == 8'h00 && mm_o == 8'h00 && hh_o == 8'h00
      |=> dec(ss_o) == int'(SEC_MOD) - 1 && dec(mm_o) == int'(MIN_MOD) - 1 && dec(hh_o) == int'(HOUR_MOD) - 1); // R7

   AST_STEP_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_fwd_i && step_back_i && !sec_tick_i && !preset_i |=> $stable(ss_o) && $stable(mm_o) && $stable(hh_o)); // R8

endmodule

bind bcd_tod_counter bcd_tod_checker #(
   .SEC_MOD  (SEC_MOD),
   .MIN_MOD  (MIN_MOD),
   .HOUR_MOD (HOUR_MOD)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .sec_tick_i  (sec_tick_i),
   .step_fwd_i  (step_fwd_i),
   .step_back_i (step_back_i),
   .preset_i    (preset_i),
   .preset_hh_i (preset_hh_i),
   .preset_mm_i (preset_mm_i),
   .preset_ss_i (preset_ss_i),
   .hh_o        (hh_o),
   .mm_o        (mm_o),
   .ss_o        (ss_o)
);

// File: tb/bcd_tod_counter_tb.sv
module bcd_tod_counter_tb;

   localparam int DAY = 86400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, fwd = 1'b0, back = 1'b0, pre = 1'b0;
   logic [7:0] p_hh = '0, p_mm = '0, p_ss = '0;
   logic [7:0] hh, mm, ss;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    tod     = 0;
   bit    started = 1'b0;
   string phase   = "R1";

   always #2 clk = ~clk;

   bcd_tod_counter u_dut (
      .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(tick), .step_fwd_i(fwd), .step_back_i(back),
      .preset_i(pre), .preset_hh_i(p_hh), .preset_mm_i(p_mm), .preset_ss_i(p_ss),
      .hh_o(hh), .mm_o(mm), .ss_o(ss)
   );

   function automatic logic [7:0] bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic bit ok_byte(input logic [7:0] b, input int m);
      return b[7:4] <= 4'd9 && b[3:0] <= 4'd9 && (int'(b[7:4]) * 10 + int'(b[3:0])) < m;
   endfunction

   function automatic int val(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [23:0] exp_time(input int t);
      return {bcd(t / 3600), bcd((t / 60) % 60), bcd(t % 60)};
   endfunction

   // Behavioural reference: seconds of the day
   always @(posedge clk) begin
      started <= 1'b1;
      if (!rst_n) tod = 0;
      else if (pre && ok_byte(p_hh, 24) && ok_byte(p_mm, 60) && ok_byte(p_ss, 60))
         tod = val(p_hh) * 3600 + val(p_mm) * 60 + val(p_ss);
      else
         tod = (tod + int'(tick) + int'(fwd) - int'(back) + DAY) % DAY;
   end

   // Compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         n_tests++;
         if ({hh, mm, ss} !== exp_time(tod)) begin
            n_fail++;
            $display("FAIL %s: model compare got %h:%h:%h expected %h", phase, hh, mm, ss, exp_time(tod));
         end
      end
   end

   task automatic expect_time(input string req, input logic [23:0] e);
      n_tests++;
      if ({hh, mm, ss} !== e) begin
         n_fail++;
         $display("FAIL %s: got %h:%h:%h expected %h:%h:%h", req, hh, mm, ss, e[23:16], e[15:8], e[7:0]);
      end
   endtask

   task automatic step(input logic t, input logic f, input logic b);
      tick = t; fwd = f; back = b;
      @(negedge clk);
      tick = 1'b0; fwd = 1'b0; back = 1'b0;
   endtask

   task automatic load(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      pre = 1'b1; p_hh = h; p_mm = m; p_ss = s;
      @(negedge clk);
      pre = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      expect_time("R1", 24'h000000);
      rst_n = 1'b1;
      @(negedge clk);
      expect_time("R1", 24'h000000);

      phase = "R11"; idle(4); expect_time("R11", 24'h000000);
      phase = "R3";
      step(1, 0, 0); expect_time("R3", 24'h000001);
      idle(2); expect_time("R11", 24'h000001);
      load(8'h00, 8'h00, 8'h58); expect_time("R9", 24'h000058);
      step(1, 0, 0); step(1, 0, 0); expect_time("R3", 24'h000100);
      load(8'h00, 8'h00, 8'h09); step(1, 0, 0); expect_time("R3", 24'h000010);
      phase = "R4";
      load(8'h00, 8'h59, 8'h59); step(1, 0, 0); expect_time("R4", 24'h010000);
      load(8'h09, 8'h59, 8'h59); step(1, 0, 0); expect_time("R4", 24'h100000);
      load(8'h23, 8'h59, 8'h59); step(1, 0, 0); expect_time("R4", 24'h000000);
      phase = "R5";
      load(8'h12, 8'h34, 8'h59); step(0, 1, 0); expect_time("R5", 24'h123500);
      phase = "R6";
      load(8'h10, 8'h00, 8'h00); step(0, 0, 1); expect_time("R6", 24'h095959);
      load(8'h05, 8'h30, 8'h10); step(0, 0, 1); expect_time("R6", 24'h053009);
      phase = "R7";
      load(8'h00, 8'h00, 8'h00); step(0, 0, 1); expect_time("R7", 24'h235959);
      phase = "R8";
      load(8'h23, 8'h59, 8'h58); step(1, 1, 0); expect_time("R8", 24'h000000);
      load(8'h11, 8'h59, 8'h59); step(1, 1, 0); expect_time("R8", 24'h120001);
      step(1, 0, 1); expect_time("R8", 24'h120001);
      step(0, 1, 1); expect_time("R8", 24'h120001);
      step(1, 1, 1); expect_time("R8", 24'h120002);
      phase = "R9";
      tick = 1'b1; fwd = 1'b1; load(8'h07, 8'h08, 8'h09); tick = 1'b0; fwd = 1'b0;
      expect_time("R9", 24'h070809);
      phase = "R10";
      load(8'h24, 8'h00, 8'h00); expect_time("R10", 24'h070809);
      load(8'h00, 8'h60, 8'h00); expect_time("R10", 24'h070809);
      load(8'h00, 8'h00, 8'h5A); expect_time("R10", 24'h070809);
      load(8'hA1, 8'h00, 8'h00); expect_time("R10", 24'h070809);
      tick = 1'b1; load(8'h00, 8'h0F, 8'h00); tick = 1'b0; expect_time("R10", 24'h070810);

      phase = "R2";
      for (int i = 0; i < 4000; i++) begin
         tick = ($urandom % 3) == 0;
         fwd  = ($urandom % 6) == 0;
         back = ($urandom % 6) == 0;
         pre  = ($urandom % 40) == 0;
         if ($urandom % 2 == 0) begin
            p_hh = bcd(int'($urandom % 24));
            p_mm = bcd(int'($urandom % 60));
            p_ss = bcd(int'($urandom % 60));
         end else begin
            p_hh = 8'($urandom); p_mm = 8'($urandom); p_ss = 8'($urandom);
         end
         @(negedge clk);
      end
      tick = 1'b0; fwd = 1'b0; back = 1'b0; pre = 1'b0;
      idle(2);
      finish_run();
   end

endmodule